// File: doc/BRIEF.md
# Break-Protected Timer Status Flag Bank

This block keeps a bank of timer status flags, for example a counter overflow flag and one event flag per capture/compare channel. Hardware sets a flag with a one-cycle pulse. Software clears a flag with a two-step handshake:

1. Read the status register while the flag is high. This arms the flag.
2. Write a zero into that flag's bit position.

A write of zero that is not preceded by an arming read does nothing. This protects against blind clears that would lose a fresh event.

A debug break input marks the periods in which a debugger may be inspecting registers. A control bit, the break-clear permit, chooses how register accesses behave while break is high:

- **Permit set:** accesses during break behave exactly as they do outside break.
- **Permit clear (the reset value):** status reads and writes during break leave every flag and every arm state untouched.

A first step taken before break therefore survives the break. The matching second step, taken after break ends, still completes the clear.

Top module: `brk_flag_bank`

## Requirements
- R1: After reset every flag output is 0, every arm state is clear, and the break-clear permit (control register, address 1, bit 0) reads 0.
- R2: A pulse on `set_i[i]` makes `flags_o[i]` high from the next clock edge on. This happens whether or not break is active. The flag holds until it is cleared.
- R3: A status read (address 0, bit i = flag i) taken while flag i is high and access is permitted arms flag i. A later permitted status write with bit i = 0 then clears flag i at that write's clock edge.
- R4: A status write leaves flag i unchanged in two cases: when bit i of the written data is 1, and when flag i was not armed by an earlier read.
- R5: If `set_i[i]` pulses in the same cycle as a write that would clear flag i, the flag stays high.
- R6: With the permit set, a status read and write during break clear a flag. A flag cleared this way stays cleared after break ends.
- R7: With the permit clear, status reads and writes during break change no flag and no arm state. A read made during such a break does not arm a flag for a write made after the break.
- R8: With the permit clear, a flag armed before break survives a zero-write made during break. A zero-write after break ends then clears it.
- R9: The control register can be written at any time, including during break. Reads of unmapped addresses return 0. Status bits at or above the flag count read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| brk_i | input | 1 | Debug break active |
| set_i | input | NUM_FLAGS | Per-flag hardware set pulses |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational in the default variant |
| flags_o | output | NUM_FLAGS | Current flag states |

## Verification
The hardest situation to reach is a flag that is armed by a read, then carried through a protected break, then cleared only after the break ends. Reaching it takes three things in order: an arming read before break, a zero-write plus a fresh hardware set and a read inside the break, and a zero-write after the break. The stimulus builds this sequence step by step. It checks the flag vector after each step. The post-break write must clear only the flags that were armed before the break, and must leave untouched the flag that was set and read during the break.

// File: rtl/bfb_pkg.sv
package bfb_pkg;

   // Register accesses may touch flag state when break is low,
   // or when the permit bit allows it during break.
   function automatic logic access_open(input logic brk, input logic permit);
      return !brk || permit;
   endfunction

   typedef struct packed {
      logic rd;
      logic wr;
   } bus_strb_t;

endpackage

// File: rtl/bfb_flag_cell.sv
module bfb_flag_cell (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_ev_i,
   input  logic arm_rd_i,
   input  logic clr_wr_i,
   input  logic protect_i,
   output logic flag_o,
   output logic arm_o
);

   logic flag_q;
   logic arm_q;

   // A hardware set always wins over a clear in the same cycle.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q <= 1'b0;
      end else if (set_ev_i) begin
         flag_q <= 1'b1;
      end else if (clr_wr_i && arm_q) begin
         flag_q <= 1'b0;
      end
   end

   // Arming needs a permitted read while the flag is high.
   // A completed clear disarms the flag.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         arm_q <= 1'b0;
      end else if (clr_wr_i && arm_q && !set_ev_i) begin
         arm_q <= 1'b0;
      end else if (arm_rd_i && flag_q) begin
         arm_q <= 1'b1;
      end
   end

   assign flag_o = flag_q;
   assign arm_o  = arm_q;

   p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_ev_i |=> flag_q);

   p_no_blind_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q && !arm_q) |=> flag_q);

   p_arm_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      protect_i |=> $stable(arm_q));

endmodule

// File: rtl/bfb_ctrl_reg.sv
module bfb_ctrl_reg #(
   parameter int DATA_W  = 8,
   parameter int PERM_BIT = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              permit_o
);

   logic permit_q;

   // Writable at any time, break or not.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         permit_q <= 1'b0;
      end else if (wr_i) begin
         permit_q <= wdata_i[PERM_BIT];
      end
   end

   assign permit_o = permit_q;

   p_permit_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_i |=> $stable(permit_q));

endmodule

// File: rtl/bfb_reg_decode.sv
module bfb_reg_decode #(
   parameter int NUM_FLAGS = 4,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 2,
   parameter int STAT_ADDR = 0,
   parameter int CTRL_ADDR = 1,
   parameter int PERM_BIT  = 0,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  bfb_pkg::bus_strb_t   strb_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic [DATA_W-1:0]    wdata_i,
   input  logic                 brk_i,
   input  logic                 permit_i,
   input  logic [NUM_FLAGS-1:0] flags_i,
   output logic [NUM_FLAGS-1:0] arm_rd_o,
   output logic [NUM_FLAGS-1:0] clr_wr_o,
   output logic                 ctrl_wr_o,
   output logic                 protect_o,
   output logic [DATA_W-1:0]    rdata_o
);

   localparam logic [ADDR_W-1:0] StatA = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] CtrlA = ADDR_W'(CTRL_ADDR);

   logic hit_stat;
   logic hit_ctrl;
   logic open_acc;
   logic [DATA_W-1:0] rmux;

   assign hit_stat  = (addr_i == StatA);
   assign hit_ctrl  = (addr_i == CtrlA);
   assign open_acc  = bfb_pkg::access_open(brk_i, permit_i);
   assign protect_o = !open_acc;
   assign ctrl_wr_o = strb_i.wr && hit_ctrl;

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_strobe
      assign arm_rd_o[i] = strb_i.rd && hit_stat && open_acc;
      assign clr_wr_o[i] = strb_i.wr && hit_stat && open_acc && !wdata_i[i];
   end

   always_comb begin
      rmux = '0;
      if (hit_stat) begin
         rmux[NUM_FLAGS-1:0] = flags_i;
      end else if (hit_ctrl) begin
         rmux[PERM_BIT] = permit_i;
      end
   end

   if (RDATA_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            rdata_q <= '0;
         end else if (strb_i.rd) begin
            rdata_q <= rmux;
         end
      end
      assign rdata_o = rdata_q;
   end else begin : g_rd_comb
      assign rdata_o = rmux;
   end

   p_protect_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (brk_i && !permit_i) |-> (clr_wr_o == '0 && arm_rd_o == '0));

endmodule

// File: rtl/brk_flag_bank.sv
module brk_flag_bank #(
   parameter int NUM_FLAGS = 4,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 2,
   parameter int STAT_ADDR = 0,
   parameter int CTRL_ADDR = 1,
   parameter int PERM_BIT  = 0,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 brk_i,
   input  logic [NUM_FLAGS-1:0] set_i,
   input  logic                 rd_i,
   input  logic                 wr_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic [DATA_W-1:0]    wdata_i,
   output logic [DATA_W-1:0]    rdata_o,
   output logic [NUM_FLAGS-1:0] flags_o
);

   localparam int NumAddr = 1 << ADDR_W;

   if (NUM_FLAGS < 1 || NUM_FLAGS > DATA_W) begin : g_chk_nf
      $error("flag count must be between 1 and the data width");
   end
   if (PERM_BIT < 0 || PERM_BIT >= DATA_W) begin : g_chk_pb
      $error("permit bit lies outside the data word");
   end
   if (STAT_ADDR == CTRL_ADDR || STAT_ADDR >= NumAddr || CTRL_ADDR >= NumAddr) begin : g_chk_ad
      $error("register addresses must be distinct and reachable");
   end

   bfb_pkg::bus_strb_t    strb;
   logic                  permit;
   logic                  protect;
   logic                  ctrl_wr;
   logic [NUM_FLAGS-1:0]  arm_rd;
   logic [NUM_FLAGS-1:0]  clr_wr;
   logic [NUM_FLAGS-1:0]  arm;

   assign strb.rd = rd_i;
   assign strb.wr = wr_i;

   bfb_ctrl_reg #(.DATA_W(DATA_W), .PERM_BIT(PERM_BIT)) u_ctrl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (ctrl_wr),
      .wdata_i  (wdata_i),
      .permit_o (permit)
   );

   bfb_reg_decode #(
      .NUM_FLAGS (NUM_FLAGS), .DATA_W (DATA_W), .ADDR_W (ADDR_W),
      .STAT_ADDR (STAT_ADDR), .CTRL_ADDR (CTRL_ADDR),
      .PERM_BIT  (PERM_BIT),  .RDATA_REG (RDATA_REG)
   ) u_dec (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .strb_i    (strb),
      .addr_i    (addr_i),
      .wdata_i   (wdata_i),
      .brk_i     (brk_i),
      .permit_i  (permit),
      .flags_i   (flags_o),
      .arm_rd_o  (arm_rd),
      .clr_wr_o  (clr_wr),
      .ctrl_wr_o (ctrl_wr),
      .protect_o (protect),
      .rdata_o   (rdata_o)
   );

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_cell
      bfb_flag_cell u_cell (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .set_ev_i  (set_i[i]),
         .arm_rd_i  (arm_rd[i]),
         .clr_wr_i  (clr_wr[i]),
         .protect_i (protect),
         .flag_o    (flags_o[i]),
         .arm_o     (arm[i])
      );

      p_flag_kept_in_break_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (brk_i && !permit && flags_o[i]) |=> flags_o[i]);

      p_clear_follows_arm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (flags_o[i] && !set_i[i] && arm[i] && wr_i && !brk_i
          && addr_i == ADDR_W'(STAT_ADDR) && !wdata_i[i]) |=> !flags_o[i]);
   end

endmodule

// File: tb/brk_flag_bank_tb.sv
module brk_flag_bank_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NF = 4;
   localparam int DW = 8;
   localparam int AW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          brk = 1'b0;
   logic [NF-1:0] set = '0;
   logic          rd = 1'b0;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic [NF-1:0] flags;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic [DW-1:0] exp;
      string         tag;
   } exp_item_t;

   exp_item_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   brk_flag_bank u_dut (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .brk_i   (brk),
      .set_i   (set),
      .rd_i    (rd),
      .wr_i    (wr),
      .addr_i  (addr),
      .wdata_i (wdata),
      .rdata_o (rdata),
      .flags_o (flags)
   );

   // Monitor: takes the expected value out of the scoreboard for each read
   always @(negedge clk) begin
      if (rd) begin
         n_cmp++;
         if (sb_q.size() == 0) begin
            n_bad++;
            $display("FAIL %s: unexpected read, actual %0h expected none", "R9", rdata);
         end else begin
            exp_item_t it;
            it = sb_q.pop_front();
            if (rdata !== it.exp) begin
               n_bad++;
               $display("FAIL %s: rdata actual %0h expected %0h", it.tag, rdata, it.exp);
            end
         end
      end
   end

   task automatic drive(input logic r, input logic w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [NF-1:0] s);
      @(posedge clk); #1;
      rd = r; wr = w; addr = a; wdata = d; set = s;
   endtask

   task automatic rd_exp(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
      exp_item_t it;
      it.exp = e;
      it.tag = tag;
      sb_q.push_back(it);
      drive(1'b1, 1'b0, a, '0, '0);
   endtask

   task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NF-1:0] s);
      drive(1'b0, 1'b1, a, d, s);
   endtask

   task automatic pulse(input logic [NF-1:0] s);
      drive(1'b0, 1'b0, '0, '0, s);
   endtask

   task automatic set_brk(input logic v);
      @(posedge clk); #1;
      rd = 1'b0; wr = 1'b0; set = '0; brk = v;
   endtask

   task automatic chk_flags(input logic [NF-1:0] e, input string tag);
      drive(1'b0, 1'b0, '0, '0, '0);
      @(negedge clk);
      n_cmp++;
      if (flags !== e) begin
         n_bad++;
         $display("FAIL %s: flags actual %b expected %b", tag, flags, e);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      chk_flags(4'b0000, "R1");
      rd_exp(2'd0, 8'h00, "R1");
      rd_exp(2'd1, 8'h00, "R1");
      // R2 set pulses
      pulse(4'b0101);
      chk_flags(4'b0101, "R2");
      rd_exp(2'd0, 8'h05, "R2");           // arms flags 0 and 2
      // R3 clear flag 0; R4 writing 1 keeps flag 2
      wr_reg(2'd0, 8'hFE, '0);
      chk_flags(4'b0100, "R3");
      // R4 unarmed flag 1 ignores the zero-write, armed flag 2 clears
      pulse(4'b0010);
      chk_flags(4'b0110, "R2");
      wr_reg(2'd0, 8'h00, '0);
      chk_flags(4'b0010, "R4");
      // R5 set coincides with clearing write
      rd_exp(2'd0, 8'h02, "R5");
      wr_reg(2'd0, 8'h00, 4'b0010);
      chk_flags(4'b0010, "R5");
      rd_exp(2'd0, 8'h02, "R3");
      wr_reg(2'd0, 8'h00, '0);
      chk_flags(4'b0000, "R3");
      // R8 / R7 protected break
      pulse(4'b0011);
      rd_exp(2'd0, 8'h03, "R8");           // arm 0 and 1 before break
      set_brk(1'b1);
      wr_reg(2'd0, 8'h00, '0);
      chk_flags(4'b0011, "R8");
      pulse(4'b1000);                      // R2 set still works in break
      chk_flags(4'b1011, "R2");
      rd_exp(2'd0, 8'h0B, "R7");           // must not arm flag 3
      wr_reg(2'd0, 8'h00, '0);
      chk_flags(4'b1011, "R7");
      set_brk(1'b0);
      wr_reg(2'd0, 8'h00, '0);
      chk_flags(4'b1000, "R8");
      wr_reg(2'd0, 8'h00, '0);
      chk_flags(4'b1000, "R7");
      // R6 permitted break
      wr_reg(2'd1, 8'h01, '0);
      rd_exp(2'd1, 8'h01, "R9");
      set_brk(1'b1);
      rd_exp(2'd0, 8'h08, "R6");
      wr_reg(2'd0, 8'h00, '0);
      chk_flags(4'b0000, "R6");
      set_brk(1'b0);
      chk_flags(4'b0000, "R6");
      // R9 map details and control write during break
      rd_exp(2'd2, 8'h00, "R9");
      rd_exp(2'd3, 8'h00, "R9");
      pulse(4'b1111);
      rd_exp(2'd0, 8'h0F, "R9");
      set_brk(1'b1);
      wr_reg(2'd1, 8'h00, '0);
      rd_exp(2'd1, 8'h00, "R9");
      set_brk(1'b0);
      drive(1'b0, 1'b0, '0, '0, '0);
      repeat (2) @(posedge clk);
      if (sb_q.size() != 0) begin
         n_bad++;
         $display("FAIL R9: pending reads actual %0d expected 0", sb_q.size());
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule